// File: doc/BRIEF.md
# UART Core with Interrupt FIFOs

This block is a memory-mapped serial port for 8N1 framing: eight data bits sent least significant bit first, one start bit, one stop bit and no parity. Software pushes characters into a transmit FIFO through the data register. A serializer drains that FIFO onto the TX pin. A deserializer assembles frames from the RX pin into a receive FIFO, and software pops them from the same data register. Bit timing comes from a one-cycle `tick16` strobe supplied by an external baud generator at sixteen times the bit rate.

Two interrupt outputs serve the FIFOs. The receive side stays pending while the receive fill count is at or above a programmable threshold. The transmit side is raised only when the transmit fill count moves from above its threshold to at or below it. Software can force either pending bit and clears them with write-one-to-clear semantics. Status reporting has three parts: a full flag and a transmitter-idle flag in the status register, and a packed level register that carries both fill counts.

Register map (word index on `busAddr`): 0 data, 1 status, 2 level, 3 FIFO configuration, 4 control, 5 interrupt enable, 6 interrupt pending (read, or write 1 to force), 7 interrupt clear (write 1 to clear).

Top module: `uart_fifo_core`

## Requirements
- R1: After reset, `txPin` is 1, the status register reads 0x20, the level register reads 0, both interrupt outputs are 0, and a data-register read returns 0.
- R2: A write to address 0 pushes `busWrData[7:0]` into the TX FIFO. The write is ignored when the FIFO already holds DEPTH bytes. Status bit 0 is 1 exactly when the TX FIFO holds DEPTH bytes. Level bits 5:0 give the TX fill count.
- R3: With control bit 0 set, the serializer sends each TX FIFO byte on `txPin`: a low start bit, then data bits LSB first, then a high stop bit, each bit lasting 16 ticks. Status bit 5 is 1 only when the TX FIFO is empty and no frame is being shifted.
- R4: With control bit 1 set, a start bit is accepted only if it stays low for 8 ticks. Each data bit is then sampled 16 ticks later, near its middle. A byte is stored only if its stop bit samples high. With control bit 1 clear, nothing is received.
- R5: A read of address 0 pops the RX FIFO and returns its oldest byte in bits 7:0, or 0 when the FIFO is empty. Level bits 11:6 give the RX fill count.
- R6: A complete frame that arrives while the RX FIFO holds DEPTH bytes is dropped, and the stored bytes are unchanged.
- R7: With control bit 2 set, the receiver takes its input from the transmitter output instead of `rxPin`.
- R8: Writing 1 to bit 0 or bit 1 of the FIFO configuration register empties the RX or TX FIFO respectively. These two bits read back as 0. The register stores the RX threshold code in bits 3:2 and the TX threshold code in bits 6:5.
- R9: The RX pending bit (bit 1 of address 6) is set in every cycle in which the RX count is at or above the RX threshold. Code 0 gives a threshold of 1, and code c>0 gives DEPTH>>(4-c).
- R10: The TX pending bit (bit 0 of address 6) is set only in the cycle after the TX count moves from above its threshold to at or below it. Code 0 gives a threshold of 0, and code c>0 gives DEPTH>>(4-c). A count that merely stays at or below the threshold does not set it.
- R11: Writing 1 to bit 0 or bit 1 of address 6 sets the TX or RX pending bit. Writing 1 to the same bits of address 7 clears them. Zero bits in either write have no effect.
- R12: `txIrq` equals the TX pending bit gated by bit 0 of address 5, and `rxIrq` equals the RX pending bit gated by bit 1 of address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (pops RX on address 0) |
| busAddr | input | 3 | Register word index |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from address |
| rxPin | input | 1 | Serial receive line |
| txPin | output | 1 | Serial transmit line |
| txIrq | output | 1 | Transmit interrupt |
| rxIrq | output | 1 | Receive interrupt |

## Verification
The bench builds the core with DEPTH=8. This lets nine frames reach both the full flag and the dropped-byte case, and it makes threshold codes 1 to 3 map to fill counts of 1, 2 and 4. The baud strobe fires every third clock, so the counters must hold their value across cycles that carry no tick. The bench also sends a start pulse only 4 ticks long, to check the start-bit rejection, and it checks the TX threshold crossing while the FIFO is drained by live transmission.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;
  typedef enum logic [2:0] {
    REG_DATA     = 3'd0,
    REG_STATUS   = 3'd1,
    REG_LEVEL    = 3'd2,
    REG_FIFOCFG  = 3'd3,
    REG_CTRL     = 3'd4,
    REG_INTCTRL  = 3'd5,
    REG_INTSTATE = 3'd6,
    REG_INTCLR   = 3'd7
  } regAddr_e;

  // strobes and enables from control to datapath
  typedef struct packed {
    logic       txPush;
    logic [7:0] txByte;
    logic       rxPop;
    logic       txFlush;
    logic       rxFlush;
    logic       txEn;
    logic       rxEn;
    logic       loopEn;
  } dpCmd_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= din;
  end

  // R2 R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !flush && count == CW'(DEPTH)) |=> $stable(count));
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && !flush && count == '0) |=> count == '0);
endmodule

// File: rtl/uart_datapath.sv
module uart_datapath
  import uart_core_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  dpCmd_t        cmd,
  input  logic          rxPin,
  output logic          txPin,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic [7:0]    rxHead,
  output logic          txBusy
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_e;

  logic [7:0] txData;
  logic [8:0] txShift;
  logic [3:0] txTick, txBit;
  logic       txLine, txPop;

  logic       rxMeta, rxSync, rxLine, rxPush;
  rxState_e   rxState;
  logic [3:0] rxTick;
  logic [2:0] rxBit;
  logic [7:0] rxShift;

  uart_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(cmd.txFlush), .push(cmd.txPush),
    .pop(txPop), .din(cmd.txByte), .dout(txData), .count(txCount));

  uart_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(cmd.rxFlush), .push(rxPush),
    .pop(cmd.rxPop), .din(rxShift), .dout(rxHead), .count(rxCount));

  // serializer
  assign txPop = !txBusy && cmd.txEn && !cmd.txFlush && (txCount != '0);
  assign txPin = txLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txLine  <= 1'b1;
      txShift <= '1;
      txTick  <= '0;
      txBit   <= '0;
    end else if (txPop) begin
      txBusy  <= 1'b1;
      txLine  <= 1'b0;
      txShift <= {1'b1, txData};
      txTick  <= '0;
      txBit   <= '0;
    end else if (txBusy && tick) begin
      txTick <= txTick + 1'b1;
      if (txTick == 4'd15) begin
        if (txBit == 4'd9) begin
          txBusy <= 1'b0;
          txLine <= 1'b1;
        end else begin
          txLine  <= txShift[0];
          txShift <= {1'b1, txShift[8:1]};
          txBit   <= txBit + 1'b1;
        end
      end
    end
  end

  // deserializer
  assign rxLine = cmd.loopEn ? txLine : rxSync;
  assign rxPush = (rxState == RX_STOP) && tick && (rxTick == 4'd15) && rxLine && cmd.rxEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxSync  <= 1'b1;
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxBit   <= '0;
      rxShift <= '0;
    end else begin
      rxMeta <= rxPin;
      rxSync <= rxMeta;
      case (rxState)
        RX_IDLE: if (cmd.rxEn && !rxLine) begin
          rxState <= RX_START;
          rxTick  <= '0;
        end
        RX_START: if (tick) begin
          if (rxLine) rxState <= RX_IDLE;
          else if (rxTick == 4'd7) begin
            rxState <= RX_DATA;
            rxTick  <= '0;
            rxBit   <= '0;
          end else rxTick <= rxTick + 1'b1;
        end
        RX_DATA: if (tick) begin
          rxTick <= rxTick + 1'b1;
          if (rxTick == 4'd15) begin
            rxShift <= {rxLine, rxShift[7:1]};
            rxBit   <= rxBit + 1'b1;
            if (rxBit == 3'd7) rxState <= RX_STOP;
          end
        end
        default: if (tick) begin
          rxTick <= rxTick + 1'b1;
          if (rxTick == 4'd15) rxState <= RX_IDLE;
        end
      endcase
    end
  end

  // R3
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txPin);
  // R3
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txPin);
  // R4
  rx_stop_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_STOP && tick && rxTick == 4'd15 && !rxLine) |=> $stable(rxCount) || $past(cmd.rxPop) || $past(cmd.rxFlush));
endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_core_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [2:0]    addr,
  input  logic [31:0]   wrData,
  output logic [31:0]   rdData,
  output dpCmd_t        cmd,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic [7:0]    rxHead,
  input  logic          txBusy,
  output logic          txIrq,
  output logic          rxIrq
);
  regAddr_e   regSel;
  logic       txEn, rxEn, loopEn, txIe, rxIe;
  logic [1:0] rxCode, txCode;
  logic       txPend, rxPend, txPrev;
  logic [CW-1:0] rxThr, txThr;
  logic       txCond, rxCond, txSet, rxSet, txClr, rxClr, forceWr, clearWr;
  logic       unusedWrBits;

  assign regSel       = regAddr_e'(addr);
  assign unusedWrBits = ^wrData[31:8];

  assign cmd.txPush  = wrEn && regSel == REG_DATA;
  assign cmd.txByte  = wrData[7:0];
  assign cmd.rxPop   = rdEn && regSel == REG_DATA;
  assign cmd.rxFlush = wrEn && regSel == REG_FIFOCFG && wrData[0];
  assign cmd.txFlush = wrEn && regSel == REG_FIFOCFG && wrData[1];
  assign cmd.txEn    = txEn;
  assign cmd.rxEn    = rxEn;
  assign cmd.loopEn  = loopEn;

  assign rxThr  = (rxCode == 2'd0) ? CW'(1) : CW'(DEPTH >> (32'd4 - 32'(rxCode)));
  assign txThr  = (txCode == 2'd0) ? CW'(0) : CW'(DEPTH >> (32'd4 - 32'(txCode)));
  assign rxCond = rxCount >= rxThr;
  assign txCond = txCount <= txThr;

  assign forceWr = wrEn && regSel == REG_INTSTATE;
  assign clearWr = wrEn && regSel == REG_INTCLR;
  assign txSet   = (txCond && !txPrev) || (forceWr && wrData[0]);
  assign rxSet   = rxCond || (forceWr && wrData[1]);
  assign txClr   = clearWr && wrData[0];
  assign rxClr   = clearWr && wrData[1];

  assign txIrq = txPend && txIe;
  assign rxIrq = rxPend && rxIe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {txEn, rxEn, loopEn, txIe, rxIe} <= '0;
      rxCode <= '0;
      txCode <= '0;
      txPend <= 1'b0;
      rxPend <= 1'b0;
      txPrev <= 1'b1;
    end else begin
      txPrev <= txCond;
      txPend <= txSet ? 1'b1 : (txClr ? 1'b0 : txPend);
      rxPend <= rxSet ? 1'b1 : (rxClr ? 1'b0 : rxPend);
      if (wrEn) begin
        case (regSel)
          REG_FIFOCFG: begin
            rxCode <= wrData[3:2];
            txCode <= wrData[6:5];
          end
          REG_CTRL:    {loopEn, rxEn, txEn} <= wrData[2:0];
          REG_INTCTRL: {rxIe, txIe} <= wrData[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      REG_DATA:     rdData = {24'b0, (rxCount != '0) ? rxHead : 8'h00};
      REG_STATUS:   rdData = {26'b0, (txCount == '0) && !txBusy, 4'b0, txCount == CW'(DEPTH)};
      REG_LEVEL:    rdData = (32'(rxCount) << 6) | 32'(txCount);
      REG_FIFOCFG:  rdData = {25'b0, txCode, 1'b0, rxCode, 2'b00};
      REG_CTRL:     rdData = {29'b0, loopEn, rxEn, txEn};
      REG_INTCTRL:  rdData = {30'b0, rxIe, txIe};
      REG_INTSTATE: rdData = {30'b0, rxPend, txPend};
      default:      rdData = '0;
    endcase
  end

  // R10
  tx_sit_no_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCond && txPrev && !forceWr && !txPend) |=> !txPend);
  // R11
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txClr && !(txCond && !txPrev)) |=> !txPend);
  // R9
  rx_level_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCond |=> rxPend);
endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core
  import uart_core_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick16,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        rxPin,
  output logic        txPin,
  output logic        txIrq,
  output logic        rxIrq
);
  dpCmd_t        cmd;
  logic [CW-1:0] txCount, rxCount;
  logic [7:0]    rxHead;
  logic          txBusy;

  uart_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .rdEn(busRdEn), .addr(busAddr),
    .wrData(busWrData), .rdData(busRdData), .cmd(cmd), .txCount(txCount),
    .rxCount(rxCount), .rxHead(rxHead), .txBusy(txBusy), .txIrq(txIrq), .rxIrq(rxIrq));

  uart_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .tick(tick16), .cmd(cmd), .rxPin(rxPin), .txPin(txPin),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead), .txBusy(txBusy));
endmodule

// File: tb/uart_fifo_core_tb.sv
module uart_fifo_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int TICK_DIV = 3;
  localparam int BIT_CYC = 16 * TICK_DIV;
  localparam int FRAME_CYC = 10 * BIT_CYC;

  logic clk = 1'b0, rstN = 1'b0, tick16 = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0, rxPin = 1'b1;
  logic [2:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic txPin, txIrq, rxIrq;
  int checks = 0, errors = 0, tickCnt = 0;
  logic [31:0] rd;
  logic [7:0] expQ [DEPTH + 1];

  uart_fifo_core #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .rxPin(rxPin), .txPin(txPin), .txIrq(txIrq), .rxIrq(rxIrq));

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tickCnt <= (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
    tick16  <= (tickCnt == 0);
  end

  function automatic logic [31:0] levelWord(int rx, int tx);
    return (32'(rx) << 6) | 32'(tx);
  endfunction
  function automatic logic [31:0] statusWord(int txCnt, bit busy);
    return {26'b0, (txCnt == 0) && !busy, 4'b0, txCnt == DEPTH};
  endfunction
  function automatic logic [31:0] cfgWord(int rxc, int txc, bit fRx, bit fTx);
    return (32'(txc) << 5) | (32'(rxc) << 2) | (32'(fTx) << 1) | 32'(fRx);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] b);
    logic [9:0] bits;
    bits = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rxPin = bits[i];
      repeat (BIT_CYC - 1) @(negedge clk);
    end
  endtask

  task automatic recvTx(output logic [7:0] b, output bit stopOk);
    int guard = 0;
    b = '0;
    while (txPin === 1'b1 && guard < 4 * FRAME_CYC) begin
      @(negedge clk); guard++;
    end
    repeat (BIT_CYC + BIT_CYC / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      b[i] = txPin;
      repeat (BIT_CYC) @(negedge clk);
    end
    stopOk = (txPin === 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    bit ok;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 txPin", 32'(txPin), 32'd1);
    check("R1 irqs", {30'b0, rxIrq, txIrq}, 32'd0);
    busRead(3'd1, rd); check("R1 status", rd, statusWord(0, 0));
    busRead(3'd2, rd); check("R1 level", rd, levelWord(0, 0));
    busRead(3'd0, rd); check("R1 R5 empty data read", rd, 32'd0);

    // R2 fill TX with transmitter disabled
    for (int i = 0; i < DEPTH - 1; i++) busWrite(3'd0, $urandom & 32'hff);
    busRead(3'd1, rd); check("R2 not full", rd, statusWord(DEPTH - 1, 0));
    for (int i = 0; i < 3; i++) busWrite(3'd0, $urandom & 32'hff);
    busRead(3'd1, rd); check("R2 full flag", rd, statusWord(DEPTH, 0));
    busRead(3'd2, rd); check("R2 overflow ignored", rd, levelWord(0, DEPTH));

    // R8 flush TX, set TX code 3
    busWrite(3'd3, cfgWord(0, 3, 0, 1));
    busRead(3'd2, rd); check("R8 tx flush", rd, levelWord(0, 0));
    busRead(3'd3, rd); check("R8 cfg readback", rd, cfgWord(0, 3, 0, 0));

    // R3 serial output on pin
    busWrite(3'd4, 32'h1);
    b = 8'($urandom);
    busWrite(3'd0, 32'(b));
    recvTx(expQ[0], ok);
    check("R3 tx byte", 32'(expQ[0]), 32'(b));
    check("R3 stop bit", 32'(ok), 32'd1);
    repeat (BIT_CYC) @(negedge clk);
    busRead(3'd1, rd); check("R3 idle after frame", rd, statusWord(0, 0));

    // R10 threshold crossing
    busWrite(3'd7, 32'h3);
    busWrite(3'd5, 32'h1);
    repeat (5) @(negedge clk);
    check("R10 no set while sitting", 32'(txIrq), 32'd0);
    busWrite(3'd4, 32'h0);
    for (int i = 0; i < 6; i++) busWrite(3'd0, $urandom & 32'hff);
    busWrite(3'd4, 32'h1);
    repeat (100) @(negedge clk);
    check("R10 above threshold", 32'(txIrq), 32'd0);
    repeat (FRAME_CYC) @(negedge clk);
    check("R10 crossing sets", 32'(txIrq), 32'd1);
    busWrite(3'd7, 32'h0);
    check("R11 zero clear no effect", 32'(txIrq), 32'd1);
    busWrite(3'd7, 32'h1);
    check("R11 clear", 32'(txIrq), 32'd0);
    busWrite(3'd6, 32'h1);
    check("R11 force", 32'(txIrq), 32'd1);
    busWrite(3'd5, 32'h0);
    check("R12 masked", 32'(txIrq), 32'd0);
    busRead(3'd6, rd); check("R12 pending kept", rd & 32'h1, 32'h1);
    busWrite(3'd7, 32'h1);
    repeat (6 * FRAME_CYC) @(negedge clk);

    // R7 loopback, random lengths
    busWrite(3'd4, 32'h7);
    for (int r = 0; r < 3; r++) begin
      n = 1 + int'($urandom % DEPTH);
      for (int i = 0; i < n; i++) begin
        expQ[i] = 8'($urandom);
        busWrite(3'd0, 32'(expQ[i]));
      end
      repeat ((n + 1) * FRAME_CYC) @(negedge clk);
      busRead(3'd2, rd); check("R7 R5 loop level", rd, levelWord(n, 0));
      for (int i = 0; i < n; i++) begin
        busRead(3'd0, rd); check("R7 loop data", rd, 32'(expQ[i]));
      end
    end

    // R4 external frames
    busWrite(3'd4, 32'h2);
    for (int i = 0; i < 3; i++) begin
      expQ[i] = 8'($urandom);
      sendFrame(expQ[i]);
    end
    repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      busRead(3'd0, rd); check("R4 rx data", rd, 32'(expQ[i]));
    end
    @(negedge clk); rxPin = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rxPin = 1'b1;
    repeat (FRAME_CYC) @(negedge clk);
    busRead(3'd2, rd); check("R4 short start rejected", rd, levelWord(0, 0));

    // R9 RX interrupt levels
    busWrite(3'd7, 32'h3);
    busWrite(3'd5, 32'h2);
    sendFrame(8'h3c);
    repeat (BIT_CYC) @(negedge clk);
    check("R9 rx irq code0", 32'(rxIrq), 32'd1);
    busWrite(3'd5, 32'h0);
    check("R12 rx masked", 32'(rxIrq), 32'd0);
    busRead(3'd6, rd); check("R12 rx pending", (rd >> 1) & 32'h1, 32'h1);
    busWrite(3'd3, cfgWord(2, 3, 0, 0));
    busRead(3'd0, rd); check("R5 pop", rd, 32'h3c);
    busWrite(3'd7, 32'h2);
    busWrite(3'd5, 32'h2);
    sendFrame(8'h81);
    repeat (BIT_CYC) @(negedge clk);
    check("R9 below code2 threshold", 32'(rxIrq), 32'd0);
    sendFrame(8'h18);
    repeat (BIT_CYC) @(negedge clk);
    check("R9 at code2 threshold", 32'(rxIrq), 32'd1);

    // R6 overflow drop
    busWrite(3'd3, cfgWord(0, 3, 1, 0));
    busRead(3'd2, rd); check("R8 rx flush", rd, levelWord(0, 0));
    for (int i = 0; i <= DEPTH; i++) begin
      expQ[i] = 8'($urandom);
      sendFrame(expQ[i]);
    end
    repeat (BIT_CYC) @(negedge clk);
    busRead(3'd2, rd); check("R6 full count", rd, levelWord(DEPTH, 0));
    for (int i = 0; i < DEPTH; i++) begin
      busRead(3'd0, rd); check("R6 kept data", rd, 32'(expQ[i]));
    end
    busRead(3'd0, rd); check("R6 R5 dropped byte absent", rd, 32'd0);

    // R4 receiver disabled
    busWrite(3'd4, 32'h0);
    sendFrame(8'h5a);
    repeat (BIT_CYC) @(negedge clk);
    busRead(3'd2, rd); check("R4 rx disabled", rd, levelWord(0, 0));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule